// File: doc/BRIEF.md
# GPIO Pad Control Register Unit

This block keeps the configuration of a small bank of general-purpose pads. Each pad owns two registers on a simple register bus. A control register chooses the pad function, the bias, the drive strength and the direction. A data register carries the output level and reports a synchronized copy of the pad input. The block drives the pad-side signals directly: output value, output enable, bias selection and drive code. It also exports the function code, which steers an external function multiplexer.

Function code zero is plain GPIO. In that mode the pad output and enable come from the registers. Any other code hands the output and enable over to the selected alternate-function port. The bias field has a bus-keeper setting. In that setting, whenever the pad is not driven, the block holds the last sampled pad level weakly through the pull output.

Software can write the output level before setting the enable. The pad then starts driving with the intended value on its first driven cycle.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After reset every control field and every output data bit is 0. All pads are then inputs, with no pull, drive code 0 and function code 0.
- R2: Pin p has its control register at address 2p and its data register at address 2p+1. Control fields are: function code in bits 2:0, bias in bits 4:3, drive code in bits 7:5 and output enable in bit 8. All other bits read back as 0.
- R3: In the data register, bit 0 is the read-only synchronized pad input and is not changed by writes. Bit 1 is the output data bit. All other bits read back as 0.
- R4: A pad input change appears in data bit 0 two clock edges after it is first sampled, and not after one edge.
- R5: With function code 0, the pad output equals the output data bit and the pad enable equals the control enable bit. A register write takes effect on the clock edge that performs it.
- R6: A function code k in the range 1 to ALT_FUNCS selects alternate port index p*ALT_FUNCS+k-1 for both the pad output and the pad enable. That path is combinational from the alternate inputs.
- R7: The function select output of each pin always equals its function code field.
- R8: The bias field is encoded as 0 none, 1 pull-down, 2 keeper, 3 pull-up. The pull output uses the same 2-bit codes. Codes 0, 1 and 3 pass through unchanged.
- R9: The drive output equals the 3-bit drive code, where code n means 2*(n+1) mA. All eight codes from 0 to 7 pass through.
- R10: If the output data bit is written before the enable is set, the pad output already holds that value on the first cycle the pad enable is high.
- R11: A write changes only the addressed register. Addresses at or above 2*NUM_PINS are ignored on write and read as 0.
- R12: In keeper mode with the effective pad enable low, the pull output is 3 (up) when the synchronized input is 1 and 1 (down) when it is 0. With the effective enable high it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Register address |
| we_i | input | 1 | Write enable |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational from addr_i |
| pad_in_i | input | NUM_PINS | Raw pad input levels |
| pad_out_o | output | NUM_PINS | Pad output values |
| pad_oe_o | output | NUM_PINS | Pad output enables |
| pad_pull_o | output | 2*NUM_PINS | Effective bias code per pin |
| pad_drive_o | output | 3*NUM_PINS | Drive code per pin |
| func_sel_o | output | 3*NUM_PINS | Function code per pin, to the external multiplexer |
| alt_out_i | input | NUM_PINS*ALT_FUNCS | Alternate-function output values |
| alt_oe_i | input | NUM_PINS*ALT_FUNCS | Alternate-function output enables |

## Verification
The bench samples the input bit one edge and two edges after a pad change. A design with one synchronizer stage too few or too many shows the new level early or late. Every alternate code is walked with a one-hot alternate vector, which exposes an off-by-one in the selection index as a pad following the wrong port. Keeper mode is checked for both input levels and with the pad driven, so a keeper that ignores the direction or inverts the level fails. Writing the output level before the enable, all-ones writes and writes to unmapped addresses catch registers that latch the read-only input, keep stray upper bits, or alias one pin onto another.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  localparam int FUNC_W     = 3;
  localparam int PULL_W     = 2;
  localparam int DRV_W      = 3;
  localparam int IO_IN_BIT  = 0;
  localparam int IO_OUT_BIT = 1;

  typedef enum logic [PULL_W-1:0] {
    PULL_NONE = 2'd0,
    PULL_DOWN = 2'd1,
    PULL_KEEP = 2'd2,
    PULL_UP   = 2'd3
  } pull_e;

  // packed MSB first: oe[8] drive[7:5] pull[4:3] func[2:0]
  typedef struct packed {
    logic              oe;
    logic [DRV_W-1:0]  drive;
    pull_e             pull;
    logic [FUNC_W-1:0] func;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
  localparam logic [FUNC_W-1:0] FUNC_GPIO = '0;
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic past_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  // R4
  sync_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |-> chain_q[0] == $past(d_i));

  for (genvar s = 1; s < STAGES; s++) begin : g_stage_chk
    // R4
    sync_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok_q |-> chain_q[s] == $past(chain_q[s-1]));
  end
endmodule

// File: rtl/gpio_pad_pin.sv
module gpio_pad_pin
  import gpio_pad_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ALT_FUNCS   = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_ctl_i,
  input  logic                 wr_io_i,
  input  logic [CTL_W-1:0]     wdata_i,
  input  logic                 pad_in_i,
  input  logic [ALT_FUNCS-1:0] alt_out_i,
  input  logic [ALT_FUNCS-1:0] alt_oe_i,
  output logic [DATA_W-1:0]    ctl_rd_o,
  output logic [DATA_W-1:0]    io_rd_o,
  output logic                 pad_out_o,
  output logic                 pad_oe_o,
  output logic [PULL_W-1:0]    pad_pull_o,
  output logic [DRV_W-1:0]     pad_drive_o,
  output logic [FUNC_W-1:0]    func_sel_o
);
  ctl_t ctl_q;
  ctl_t wr_ctl_v;
  logic out_q;
  logic in_sync;
  logic alt_out_sel, alt_oe_sel;

  assign wr_ctl_v = ctl_t'(wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctl_q <= '0;
    else if (wr_ctl_i) ctl_q <= wr_ctl_v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      out_q <= 1'b0;
    else if (wr_io_i) out_q <= wdata_i[IO_OUT_BIT];
  end

  gpio_pad_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (in_sync)
  );

  // codes past ALT_FUNCS select nothing
  always_comb begin
    alt_out_sel = 1'b0;
    alt_oe_sel  = 1'b0;
    for (int k = 0; k < ALT_FUNCS; k++) begin
      if (ctl_q.func == FUNC_W'(k + 1)) begin
        alt_out_sel = alt_out_i[k];
        alt_oe_sel  = alt_oe_i[k];
      end
    end
  end

  always_comb begin
    if (ctl_q.func == FUNC_GPIO) begin
      pad_out_o = out_q;
      pad_oe_o  = ctl_q.oe;
    end else begin
      pad_out_o = alt_out_sel;
      pad_oe_o  = alt_oe_sel;
    end
  end

  // keeper: weak hold of last sampled level while undriven
  always_comb begin
    unique case (ctl_q.pull)
      PULL_KEEP: pad_pull_o = pad_oe_o ? PULL_NONE : (in_sync ? PULL_UP : PULL_DOWN);
      default:   pad_pull_o = ctl_q.pull;
    endcase
  end

  assign pad_drive_o = ctl_q.drive;
  assign func_sel_o  = ctl_q.func;

  always_comb begin
    ctl_rd_o = '0;
    ctl_rd_o[CTL_W-1:0] = ctl_q;
    io_rd_o = '0;
    io_rd_o[IO_IN_BIT]  = in_sync;
    io_rd_o[IO_OUT_BIT] = out_q;
  end

  // R5
  gpio_oe_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctl_i && wr_ctl_v.func == FUNC_GPIO && !wr_ctl_v.oe |=> !pad_oe_o);

  // R3
  out_bit_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_io_i |=> io_rd_o[IO_OUT_BIT] == $past(wdata_i[IO_OUT_BIT]));

  // R9
  drive_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctl_i |=> pad_drive_o == $past(wr_ctl_v.drive));

  // R8
  no_pull_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctl_i && wr_ctl_v.pull == PULL_NONE |=> pad_pull_o == PULL_NONE);

  // R11
  ctl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctl_i |=> $stable(ctl_rd_o));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pad_pkg::*;
#(
  parameter int NUM_PINS    = 6,
  parameter int ALT_FUNCS   = 7,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_REGS   = 2 * NUM_PINS,
  localparam int ADDR_W     = $clog2(NUM_REGS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          we_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  input  logic [NUM_PINS-1:0]           pad_in_i,
  output logic [NUM_PINS-1:0]           pad_out_o,
  output logic [NUM_PINS-1:0]           pad_oe_o,
  output logic [NUM_PINS*PULL_W-1:0]    pad_pull_o,
  output logic [NUM_PINS*DRV_W-1:0]     pad_drive_o,
  output logic [NUM_PINS*FUNC_W-1:0]    func_sel_o,
  input  logic [NUM_PINS*ALT_FUNCS-1:0] alt_out_i,
  input  logic [NUM_PINS*ALT_FUNCS-1:0] alt_oe_i
);
  logic [NUM_PINS-1:0]             wr_ctl, wr_io;
  logic [NUM_PINS-1:0][DATA_W-1:0] ctl_rd, io_rd;
  logic                            mapped;
  logic                            unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:CTL_W];
  assign mapped = 32'(addr_i) < NUM_REGS;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign wr_ctl[p] = we_i && (addr_i == ADDR_W'(2 * p));
    assign wr_io[p]  = we_i && (addr_i == ADDR_W'(2 * p + 1));

    gpio_pad_pin #(
      .DATA_W     (DATA_W),
      .ALT_FUNCS  (ALT_FUNCS),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_pin (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_ctl_i   (wr_ctl[p]),
      .wr_io_i    (wr_io[p]),
      .wdata_i    (wdata_i[CTL_W-1:0]),
      .pad_in_i   (pad_in_i[p]),
      .alt_out_i  (alt_out_i[p*ALT_FUNCS +: ALT_FUNCS]),
      .alt_oe_i   (alt_oe_i[p*ALT_FUNCS +: ALT_FUNCS]),
      .ctl_rd_o   (ctl_rd[p]),
      .io_rd_o    (io_rd[p]),
      .pad_out_o  (pad_out_o[p]),
      .pad_oe_o   (pad_oe_o[p]),
      .pad_pull_o (pad_pull_o[p*PULL_W +: PULL_W]),
      .pad_drive_o(pad_drive_o[p*DRV_W +: DRV_W]),
      .func_sel_o (func_sel_o[p*FUNC_W +: FUNC_W])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (addr_i == ADDR_W'(2 * p))     rdata_o = ctl_rd[p];
      if (addr_i == ADDR_W'(2 * p + 1)) rdata_o = io_rd[p];
    end
  end

  // R11
  unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !mapped |=> $stable(pad_drive_o) && $stable(func_sel_o));

  // R11
  single_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({wr_ctl, wr_io}) <= 1);
endmodule

// File: tb/gpio_pad_ctrl_tb.sv
module gpio_pad_ctrl_tb;
  localparam int NP = 6;
  localparam int NA = 7;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic [NP*2-1:0] pad_pull;
  logic [NP*3-1:0] pad_drive, func_sel;
  logic [NP*NA-1:0] alt_out = '0, alt_oe = '0;

  int n_chk = 0;
  int n_fail = 0;
  logic [8:0] m_ctl [NP];
  logic       m_out [NP];

  always #5 clk = ~clk;

  gpio_pad_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .pad_pull_o(pad_pull), .pad_drive_o(pad_drive), .func_sel_o(func_sel),
    .alt_out_i(alt_out), .alt_oe_i(alt_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; we = 1'b1;
    if (a < 2 * NP) begin
      if (a % 2 == 0) m_ctl[a/2] = d[8:0];
      else            m_out[a/2] = d[1];
    end
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input int a, output logic [31:0] d);
    addr = AW'(a);
    #1;
    d = rdata;
  endtask

  function automatic logic f_oe(input int p);
    int f = int'(m_ctl[p][2:0]);
    if (f == 0) return m_ctl[p][8];
    return alt_oe[p*NA + f - 1];
  endfunction

  function automatic logic f_out(input int p);
    int f = int'(m_ctl[p][2:0]);
    if (f == 0) return m_out[p];
    return alt_out[p*NA + f - 1];
  endfunction

  function automatic logic [1:0] f_pull(input int p);
    if (m_ctl[p][4:3] != 2'd2) return m_ctl[p][4:3];
    if (f_oe(p)) return 2'd0;
    return pad_in[p] ? 2'd3 : 2'd1;
  endfunction

  // assumes pad_in stable for at least two edges
  task automatic chk_pin(input int p, input string tag);
    logic [31:0] r;
    chk({tag, " R5/R6 oe"}, 32'(pad_oe[p]), 32'(f_oe(p)));
    chk({tag, " R5/R6 out"}, 32'(pad_out[p]), 32'(f_out(p)));
    chk({tag, " R8/R12 pull"}, 32'(pad_pull[p*2 +: 2]), 32'(f_pull(p)));
    chk({tag, " R9 drive"}, 32'(pad_drive[p*3 +: 3]), 32'(m_ctl[p][7:5]));
    chk({tag, " R7 func_sel"}, 32'(func_sel[p*3 +: 3]), 32'(m_ctl[p][2:0]));
    bus_rd(2 * p, r);
    chk({tag, " R2 ctl read"}, r, 32'(m_ctl[p]));
    bus_rd(2 * p + 1, r);
    chk({tag, " R3 io read"}, r, {30'd0, m_out[p], pad_in[p]});
  endtask

  initial begin
    #(10 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5eed_0042));
    for (int p = 0; p < NP; p++) begin m_ctl[p] = '0; m_out[p] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pad_oe", 32'(pad_oe), 0);
    chk("R1 pad_out", 32'(pad_out), 0);
    chk("R1 pull", 32'(pad_pull), 0);
    chk("R1 drive", 32'(pad_drive), 0);
    chk("R1 func", 32'(func_sel), 0);
    for (int p = 0; p < NP; p++) chk_pin(p, "R1");

    // R2 unused bits read 0
    bus_wr(2, 32'hFFFF_FFFF);
    bus_rd(2, r);
    chk("R2 all-ones ctl", r, 32'h1FF);
    bus_wr(2, 32'h0);

    // R3 input bit not writable
    bus_wr(3, 32'hFFFF_FFFD);
    bus_rd(3, r);
    chk("R3 input bit ignores write", r, 32'h0);
    bus_wr(3, 32'hFFFF_FFFF);
    bus_rd(3, r);
    chk("R3 out bit set", r, 32'h2);

    // R4 synchronizer latency
    @(negedge clk);
    pad_in[0] = 1'b1;
    @(negedge clk);
    bus_rd(1, r);
    chk("R4 after one edge", 32'(r[0]), 0);
    @(negedge clk);
    bus_rd(1, r);
    chk("R4 after two edges", 32'(r[0]), 1);
    pad_in[0] = 1'b0;
    repeat (3) @(negedge clk);

    // R10 data before enable
    bus_wr(8, 32'h0);
    bus_wr(9, 32'h2);
    chk("R10 oe still low", 32'(pad_oe[4]), 0);
    bus_wr(8, 32'h100);
    chk("R10 first driven cycle oe", 32'(pad_oe[4]), 1);
    chk("R10 first driven cycle out", 32'(pad_out[4]), 1);

    // R6 every alternate code on pin 2
    for (int k = 1; k <= NA; k++) begin
      alt_out = '0; alt_oe = '0;
      alt_out[2*NA + k - 1] = 1'b1;
      alt_oe[2*NA + k - 1]  = 1'b1;
      bus_wr(4, 32'(k));
      chk($sformatf("R6 code %0d oe", k), 32'(pad_oe[2]), 1);
      chk($sformatf("R6 code %0d out", k), 32'(pad_out[2]), 1);
      chk($sformatf("R7 code %0d", k), 32'(func_sel[2*3 +: 3]), 32'(k));
      alt_out[2*NA + k - 1] = 1'b0;
      #1;
      chk($sformatf("R6 code %0d comb out", k), 32'(pad_out[2]), 0);
    end
    alt_out = '0; alt_oe = '0;

    // R12 keeper
    bus_wr(10, 32'h10);
    pad_in[5] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 keeper high", 32'(pad_pull[10 +: 2]), 3);
    pad_in[5] = 1'b0;
    @(negedge clk);
    chk("R12 keeper lag", 32'(pad_pull[10 +: 2]), 3);
    @(negedge clk);
    chk("R12 keeper low", 32'(pad_pull[10 +: 2]), 1);
    bus_wr(10, 32'h110);
    chk("R12 keeper driven", 32'(pad_pull[10 +: 2]), 0);
    alt_oe[5*NA + 2] = 1'b1;
    bus_wr(10, 32'h013);
    chk("R12 keeper alt driven", 32'(pad_pull[10 +: 2]), 0);
    alt_oe = '0;

    // R9 all drive codes
    for (int n = 0; n < 8; n++) begin
      bus_wr(6, 32'(n) << 5);
      chk($sformatf("R9 drive %0d mA", 2 * (n + 1)), 32'(pad_drive[9 +: 3]), 32'(n));
    end

    // R11 unmapped addresses
    for (int a = 2 * NP; a < 16; a++) begin
      bus_wr(a, 32'hFFFF_FFFF);
      bus_rd(a, r);
      chk($sformatf("R11 unmapped read %0d", a), r, 0);
    end
    for (int p = 0; p < NP; p++) chk_pin(p, "R11 after unmapped");

    // random
    for (int it = 0; it < 250; it++) begin
      int p = int'($urandom_range(NP - 1, 0));
      @(negedge clk);
      pad_in  = NP'($urandom);
      alt_out = {$urandom, $urandom};
      alt_oe  = {$urandom, $urandom};
      bus_wr(2 * p, $urandom);
      bus_wr(2 * p + 1, $urandom);
      @(negedge clk);
      for (int q = 0; q < NP; q++) chk_pin(q, "rand R11");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule